// File: doc/BRIEF.md
# Stoppable Bus-Clock Gate

This block gates a group of bus-clock outputs under control of an asynchronous, active-low stop request. The request is brought into the bus-clock domain through a synchroniser. A small run/halt controller then decides cycle by cycle whether the group may pulse. Each output has its own gate cell. A gate cell updates its enable only while the bus clock is low. Because of this, a gated output is either silent or produces a full-width high phase, and it is always low while the bus clock is low. A companion output carries the bus clock ungated and ignores the stop request.

Once the group restarts, it must deliver a minimum number of pulses before a new stop can take effect. A stop request that arrives inside this window is postponed and is honoured as soon as the window closes, provided the request is still asserted. Each output also has an enable bit that forces it low on its own. A mode strap is captured while reset is asserted. When the captured strap is 1, the stop pin acts as a reference-clock output, so its input value is ignored and a flag reports that pin role.

Top module: `stoppable_clk_gate`

## Requirements
- R1: When not stopped, every enabled output `gclk[i]` gives exactly one high pulse per bus-clock cycle, and that pulse coincides with the bus-clock high phase.
- R2: A gated output never carries a runt pulse. Each high pulse lasts a full bus-clock half period, and every output is low throughout each bus-clock low phase.
- R3: The stop input `stop_n_async` passes through a two-stage synchroniser. Suppose it falls before rising edge P1 while the group is running and past its minimum window. Pulses then still appear at P1, P2 and P3, and none appear after P3.
- R4: While the group is halted, every gated output stays low.
- R5: Suppose `stop_n_async` rises before rising edge Q1 while the group is halted. No pulse appears at Q1, Q2 or Q3. The first full pulse appears at Q4.
- R6: After a restart, at least MIN_RUN (default 10) pulses are delivered before a stop takes effect. A stop that is driven low d cycles after the restart edge and then held low yields exactly max(d, MIN_RUN) pulses, so the stop is postponed but not lost.
- R7: Bit i of `out_en` enables `gclk[i]` (1 = enabled). The bit is sampled on the bus-clock rising edge. A change made before edge P1 takes effect from the pulse at P2 onward. A disabled output is held low.
- R8: `fclk` follows the bus clock at all times, including while the gated group is halted.
- R9: `mode_strap` is captured only while `rst` is high. If the captured value is 1, `ref_mode` reads 1, the stop input has no effect, and later changes of the strap input change nothing.
- R10: While `rst` is high, all gated outputs are low. If reset is released before edge P1 with the stop input inactive, the first pulse appears at P2, and `ref_mode` shows the captured strap value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset; the strap is captured while it is high |
| stop_n_async | input | 1 | Asynchronous active-low stop request for the gated group |
| mode_strap | input | 1 | Pin-role strap; 0 means the stop function is in use, 1 means the pin acts as a reference output |
| out_en | input | N_OUT | Per-output enable, 1 = enabled |
| gclk | output | N_OUT | Gated bus clocks |
| fclk | output | 1 | Free-running copy of the bus clock |
| ref_mode | output | 1 | Captured strap; 1 means the stop pin acts as a reference-clock output |

## Verification
If the run counter or the run/halt state is wrong, the error appears in the pulse counts within one stop/restart episode. A counter that is off by one changes the count of pulses after a postponed stop by exactly one, and the sweep over stop delays exposes this. A synchroniser of the wrong length moves the last and the first gated pulse by one edge in each direction. A gate enable that is updated on the wrong clock edge shows up within a single pulse as a shortened high phase or as a high level during the low phase. A wrong enable mask shows up as a wrong per-output count within eight cycles.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;

  // Run/halt state of the gated group.
  typedef enum logic {
    GATE_HALTED  = 1'b0,
    GATE_RUNNING = 1'b1
  } gate_state_t;

  // Bits needed to hold values 0..n inclusive.
  function automatic int span_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/cg_sync.sv
`timescale 1ns/1ps
module cg_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/cg_ctrl.sv
`timescale 1ns/1ps
module cg_ctrl
  import clkgate_pkg::*;
#(
  parameter int MIN_RUN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic stop_req,
  output logic run
);

  localparam int CW = span_bits(MIN_RUN);

  gate_state_t    state;
  logic [CW-1:0]  run_cnt;
  logic           window_done;

  // run_cnt holds the number of rising edges since the restart edge, saturating at MIN_RUN
  assign window_done = (run_cnt >= CW'(MIN_RUN));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= GATE_RUNNING;
      run_cnt <= CW'(MIN_RUN);
    end else begin
      case (state)
        GATE_HALTED: begin
          if (!stop_req) begin
            state   <= GATE_RUNNING;
            run_cnt <= CW'(1);
          end
        end
        default: begin
          if (stop_req && window_done) state <= GATE_HALTED;
          else if (!window_done)       run_cnt <= run_cnt + CW'(1);
        end
      endcase
    end
  end

  assign run = (state == GATE_RUNNING);

endmodule

// File: rtl/cg_gate_cell.sv
`timescale 1ns/1ps
module cg_gate_cell (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic en,
  output logic en_lat,
  output logic gclk
);

  // Updated on the falling edge, so the gate opens or closes only while clk is low.
  always_ff @(negedge clk) begin
    if (rst) en_lat <= 1'b0;
    else     en_lat <= run & en;
  end

  assign gclk = clk & en_lat;

endmodule

// File: rtl/stoppable_clk_gate.sv
`timescale 1ns/1ps
module stoppable_clk_gate #(
  parameter int N_OUT       = 5,
  parameter int MIN_RUN     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_n_async,
  input  logic             mode_strap,
  input  logic [N_OUT-1:0] out_en,
  output logic [N_OUT-1:0] gclk,
  output logic             fclk,
  output logic             ref_mode
);

  logic             strap_q;
  logic             stop_n_sync;
  logic             stop_req;
  logic             run_state;
  logic [N_OUT-1:0] en_reg;
  logic [N_OUT-1:0] en_lat;

  // The strap is captured only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) strap_q <= mode_strap;
  end

  always_ff @(posedge clk) begin
    if (rst) en_reg <= '0;
    else     en_reg <= out_en;
  end

  cg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (stop_n_async),
    .q       (stop_n_sync)
  );

  assign stop_req = ~stop_n_sync & ~strap_q;

  cg_ctrl #(.MIN_RUN(MIN_RUN)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .stop_req (stop_req),
    .run      (run_state)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_cell
    cg_gate_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .run    (run_state),
      .en     (en_reg[i]),
      .en_lat (en_lat[i]),
      .gclk   (gclk[i])
    );
  end

  assign fclk     = clk;
  assign ref_mode = strap_q;

endmodule

// File: rtl/cg_checker.sv
`timescale 1ns/1ps
module cg_checker #(
  parameter int N_OUT   = 5,
  parameter int MIN_RUN = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_mode,
  input logic             run,
  input logic             sync_n,
  input logic [N_OUT-1:0] en_reg,
  input logic [N_OUT-1:0] en_lat
);

  localparam int CW = $clog2(MIN_RUN + 1);

  // Own count of edges seen while running, starting at 0 on the restart edge.
  logic [CW-1:0] seen;
  logic          stop_seen;

  always_ff @(posedge clk) begin
    if (rst)                    seen <= CW'(MIN_RUN);
    else if (!run)              seen <= '0;
    else if (seen != CW'(MIN_RUN)) seen <= seen + CW'(1);
  end

  assign stop_seen = ~sync_n & ~ref_mode;

  // R4: a halted group leaves every gate closed
  assert_held_low_R4: assert property (@(posedge clk) disable iff (rst)
    !run |-> (en_lat == '0));

  // R7: a gate never opens for an output whose enable bit is clear
  assert_enable_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (en_lat & ~en_reg) == '0);

  // R3: a stop seen after the minimum window halts the group on the next edge
  assert_stop_honored_R3: assert property (@(posedge clk) disable iff (rst)
    (run && stop_seen && (seen >= CW'(MIN_RUN - 1))) |=> !run);

  // R6: inside the minimum window the group keeps running
  assert_min_run_R6: assert property (@(posedge clk) disable iff (rst)
    (run && (seen < CW'(MIN_RUN - 1))) |=> run);

  // R5: a released stop restarts the group on the next edge
  assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (!run && !stop_seen) |=> run);

  // R9: in reference-pin mode the group never halts
  assert_strap_run_R9: assert property (@(posedge clk) disable iff (rst)
    ref_mode |-> run);

endmodule

bind stoppable_clk_gate cg_checker #(.N_OUT(N_OUT), .MIN_RUN(MIN_RUN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ref_mode (ref_mode),
  .run      (run_state),
  .sync_n   (stop_n_sync),
  .en_reg   (en_reg),
  .en_lat   (en_lat)
);

// File: tb/stoppable_clk_gate_tb.sv
`timescale 1ns/1ps
module stoppable_clk_gate_tb;

  localparam int  N        = 5;
  localparam int  MINR     = 10;
  localparam real HALF     = 2.5;
  localparam int  MAX_CYC  = 200000;

  logic         clk = 1'b0;
  logic         rst;
  logic         stop_n_async;
  logic         mode_strap;
  logic [N-1:0] out_en;
  logic [N-1:0] gclk;
  logic         fclk;
  logic         ref_mode;

  int  total = 0;
  int  fails = 0;
  bit  done  = 1'b0;
  int  pc [N];
  int  base [N];
  int  fc = 0;
  int  fbase = 0;
  int  runt_err = 0;
  int  width_err = 0;
  real t_rise [N];

  always #(HALF) clk = ~clk;

  stoppable_clk_gate #(.N_OUT(N), .MIN_RUN(MINR), .SYNC_STAGES(2)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .stop_n_async (stop_n_async),
    .mode_strap   (mode_strap),
    .out_en       (out_en),
    .gclk         (gclk),
    .fclk         (fclk),
    .ref_mode     (ref_mode)
  );

  for (genvar g = 0; g < N; g++) begin : g_mon
    always @(posedge gclk[g]) begin
      pc[g] = pc[g] + 1;
      t_rise[g] = $realtime;
    end
    always @(negedge gclk[g]) begin
      if (($realtime - t_rise[g]) < HALF - 0.01 || ($realtime - t_rise[g]) > HALF + 0.01)
        width_err = width_err + 1;
    end
  end

  always @(posedge fclk) fc = fc + 1;

  always @(negedge clk) begin
    #1;
    if (gclk != '0) runt_err = runt_err + 1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic mark();
    for (int i = 0; i < N; i++) base[i] = pc[i];
    fbase = fc;
  endtask

  // Count outputs whose pulse count since mark differs from the expected value.
  function automatic int bad_outputs(input logic [N-1:0] mask, input int on_cnt, input int off_cnt);
    int b = 0;
    for (int i = 0; i < N; i++) begin
      if ((pc[i] - base[i]) != (mask[i] ? on_cnt : off_cnt)) b++;
    end
    return b;
  endfunction

  initial begin
    #(2.0 * HALF * MAX_CYC);
    if (!done) begin
      fails = fails + 1;
      total = total + 1;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst          = 1'b1;
    mode_strap   = 1'b0;
    stop_n_async = 1'b1;
    out_en       = '1;
    for (int i = 0; i < N; i++) begin
      pc[i] = 0;
      t_rise[i] = 0.0;
    end

    // R10: outputs low during reset (sampled in the bus-clock high phase)
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      #1;
      check("R10", "gclk in reset", int'(gclk), 0);
    end
    @(negedge clk);
    #1;
    rst = 1'b0;
    mark();
    cyc(1);
    check("R10", "outputs with pulse at first edge after release", bad_outputs('1, 0, 0), 0);
    mark();
    cyc(10);
    check("R10", "outputs with wrong count after release", bad_outputs('1, 10, 10), 0);
    check("R10", "ref_mode after reset with strap 0", int'(ref_mode), 0);

    // R1: steady running
    mark();
    cyc(20);
    check("R1", "outputs with wrong count over 20 cycles", bad_outputs('1, 20, 20), 0);

    // R3: stop after a long run gives pulses at three more edges
    stop_n_async = 1'b0;
    mark();
    cyc(10);
    check("R3", "outputs with wrong pulse count after stop", bad_outputs('1, 3, 3), 0);

    // R4 / R8: halted group stays low, free-running output continues
    mark();
    cyc(20);
    check("R4", "outputs pulsing while halted", bad_outputs('1, 0, 0), 0);
    check("R8", "fclk pulses while group halted", fc - fbase, 20);

    // R5: restart latency
    stop_n_async = 1'b1;
    mark();
    cyc(3);
    check("R5", "outputs pulsing before Q4", bad_outputs('1, 0, 0), 0);
    mark();
    cyc(10);
    check("R5", "outputs with wrong count after restart", bad_outputs('1, 10, 10), 0);

    // R6: sweep of stop delays after a restart; expect max(d, MINR) pulses
    stop_n_async = 1'b0;
    cyc(20);
    for (int d = 1; d <= 14; d++) begin
      stop_n_async = 1'b1;
      mark();
      cyc(d);
      stop_n_async = 1'b0;
      cyc(40 - d);
      check("R6", $sformatf("outputs with wrong count, stop delay %0d", d),
            bad_outputs('1, (d > MINR) ? d : MINR, 0), 0);
    end

    // R7: per-output enables
    stop_n_async = 1'b1;
    cyc(5);
    out_en = 5'b10101;
    mark();
    cyc(10);
    check("R7", "outputs with wrong count right after mask change", bad_outputs(5'b10101, 10, 1), 0);
    mark();
    cyc(10);
    check("R7", "outputs with wrong count under mask 10101", bad_outputs(5'b10101, 10, 0), 0);
    for (int m = 0; m < (1 << N); m++) begin
      out_en = N'(m);
      cyc(2);
      mark();
      cyc(8);
      check("R7", $sformatf("outputs with wrong count, mask %0d", m), bad_outputs(N'(m), 8, 0), 0);
    end

    // R9: strap 1 captured in reset makes the stop input ineffective
    rst          = 1'b1;
    mode_strap   = 1'b1;
    stop_n_async = 1'b0;
    out_en       = '1;
    cyc(4);
    rst = 1'b0;
    cyc(1);
    mode_strap = 1'b0;
    cyc(2);
    check("R9", "ref_mode with strap 1", int'(ref_mode), 1);
    mark();
    cyc(20);
    check("R9", "outputs stopped in reference-pin mode", bad_outputs('1, 20, 20), 0);
    check("R9", "ref_mode after strap change", int'(ref_mode), 1);

    // R2: no runt and full-width pulses over the whole run
    check("R2", "high level during low phase", runt_err, 0);
    check("R2", "pulses of wrong width", width_err, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule